// File: doc/BRIEF.md
# Timing-Error Detecting Pipeline Register

This block is a pipeline register for a path that may be run too fast for its logic. Every bit keeps two samples of the same data slot. The main sample is the value on `dIn` at the clock edge. The shadow sample is the value on `shadowIn`, which stands for the same logic output as it was at a clock delayed by half a period. The delayed-clock capture itself is outside the block, so the late value arrives as a separate input and is taken on the same edge as `dIn`. If the two samples differ in any bit, the main sample was taken before the logic had settled.

On the next edge that is not stalled, the block does not take new data. It copies the shadow sample into the main register and raises `errOut` for one cycle. The following stage then sees the settled value. The data that failed never passes through the failing logic again: it moves on from the shadow copy with a penalty of one cycle.

`stallIn` is the pipeline-wide freeze. It is formed outside the block as the OR of the `errOut` outputs of all protected registers. While it is high, the register keeps both of its samples, takes no input, and reports no error. If every data slot fails, the register still takes one word every two edges, so the pipeline keeps moving.

Top module: `tedRegister`

## Requirements
- R1: While `rstN` is low and on the first cycle after it rises, `qOut` is all zeros and `errOut` is 0. Reset also clears the shadow sample, so no mismatch is pending afterwards.
- R2: On a capture edge (`stallIn` low, no mismatch pending), `dIn` is taken into the main register and `shadowIn` into the shadow register. In the following cycle `qOut` equals the `dIn` that was taken and `errOut` is 0. This holds whether or not the two inputs agreed.
- R3: A mismatch is pending when the main and shadow samples differ in at least one bit position. A difference in any single bit, in any position, makes a mismatch pending.
- R4: On an edge with `stallIn` low and a mismatch pending, the shadow sample is copied into the main register and `dIn`/`shadowIn` are ignored. In the following cycle `qOut` equals the shadow sample and `errOut` is 1.
- R5: While `stallIn` is high at an edge, `qOut` and the shadow sample keep their values and `dIn`/`shadowIn` are ignored. In the following cycle `errOut` is 0. A pending mismatch stays pending and is corrected on the next edge that is not stalled.
- R6: `errOut` is never high for two cycles in a row.
- R7: After a correction, the next edge that is not stalled is a capture edge. When every slot fails, one word is still accepted every two non-stalled edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock; all state changes on its rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| dIn | input | WIDTH | Data as it stands at the main clock edge |
| shadowIn | input | WIDTH | The same data as it stood at the delayed (half-period) edge |
| stallIn | input | 1 | Pipeline-wide freeze for the current edge |
| qOut | output | WIDTH | Main register value seen by the next stage |
| errOut | output | 1 | High for the cycle after a correction edge |

## Verification
The assertions assume that `stallIn` and the data inputs settle well before each rising edge. They also assume that `stallIn` is the only source of freezing, with nothing changing the register between edges. The stimulus drives all inputs at the falling edge and holds them for a full cycle, so both assumptions hold.

Every ordered pair of main and shadow values of a 4-bit register is applied, with both equal and differing pairs. Some differing pairs get a stall edge before the correction. On every edge that should ignore the data, the inputs are changed to unrelated values, so that a wrongly taken input shows up on `qOut`.

// File: rtl/ted_pkg.sv
package ted_pkg;
  // Strobes from the control to the datapath; at most one is high per edge.
  typedef struct packed {
    logic capture;
    logic restore;
  } tedStrobe_t;
endpackage

// File: rtl/ted_datapath.sv
module ted_datapath
  import ted_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] dIn,
  input  logic [WIDTH-1:0] shadowIn,
  input  tedStrobe_t       strobe,
  output logic [WIDTH-1:0] mainVal,
  output logic [WIDTH-1:0] shadowVal,
  output logic [WIDTH-1:0] diffVec
);
  // One cell per protected bit: main flop, shadow flop, comparator.
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic mainQ;
    logic shadowQ;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        mainQ   <= 1'b0;
        shadowQ <= 1'b0;
      end else if (strobe.capture) begin
        mainQ   <= dIn[b];
        shadowQ <= shadowIn[b];
      end else if (strobe.restore) begin
        mainQ   <= shadowQ;
      end
    end

    assign mainVal[b]   = mainQ;
    assign shadowVal[b] = shadowQ;
    assign diffVec[b]   = mainQ ^ shadowQ;
  end

  // R4: after a correction edge, main and shadow agree
  restore_heals_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.restore |=> (mainVal == shadowVal));
endmodule

// File: rtl/ted_ctrl.sv
module ted_ctrl
  import ted_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             stallIn,
  input  logic [WIDTH-1:0] diffVec,
  output tedStrobe_t       strobe,
  output logic             errOut
);
  logic anyDiff;
  logic errQ;

  assign anyDiff        = |diffVec;
  assign strobe.capture = !stallIn && !anyDiff;
  assign strobe.restore = !stallIn && anyDiff;

  always_ff @(posedge clk) begin
    if (!rstN) errQ <= 1'b0;
    else       errQ <= strobe.restore;
  end

  assign errOut = errQ;

  // R6: an error never lasts two cycles
  single_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    errOut |=> !errOut);

  // R5: a stalled edge reports no error
  stall_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    stallIn |=> !errOut);
endmodule

// File: rtl/tedRegister.sv
module tedRegister
  import ted_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] dIn,
  input  logic [WIDTH-1:0] shadowIn,
  input  logic             stallIn,
  output logic [WIDTH-1:0] qOut,
  output logic             errOut
);
  tedStrobe_t       strobe;
  logic [WIDTH-1:0] mainVal;
  logic [WIDTH-1:0] shadowVal;
  logic [WIDTH-1:0] diffVec;

  ted_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .dIn      (dIn),
    .shadowIn (shadowIn),
    .strobe   (strobe),
    .mainVal  (mainVal),
    .shadowVal(shadowVal),
    .diffVec  (diffVec)
  );

  ted_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .stallIn (stallIn),
    .diffVec (diffVec),
    .strobe  (strobe),
    .errOut  (errOut)
  );

  assign qOut = mainVal;

  // R2: an agreeing, unstalled edge takes the input and stays quiet
  capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!stallIn && (qOut == shadowVal)) |=> ((qOut == $past(dIn)) && !errOut));

  // R4: a disagreeing, unstalled edge restores the shadow value and flags it
  restore_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!stallIn && (qOut != shadowVal)) |=> (errOut && (qOut == $past(shadowVal))));

  // R5: a stalled edge freezes the output
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    stallIn |=> $stable(qOut));
endmodule

// File: tb/sim_tedRegister.sv
module sim_tedRegister;
  localparam int W = 4;
  localparam int N = 1 << W;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [W-1:0] dIn = '0;
  logic [W-1:0] shadowIn = '0;
  logic         stallIn = 1'b0;
  logic [W-1:0] qOut;
  logic         errOut;

  int nChecks = 0;
  int nFail   = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  tedRegister #(.WIDTH(W)) u0 (
    .clk(clk), .rstN(rstN), .dIn(dIn), .shadowIn(shadowIn),
    .stallIn(stallIn), .qOut(qOut), .errOut(errOut)
  );

  task automatic chk(input string req, input logic [W:0] act, input logic [W:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: {err,q} actual %b expected %b", req, act, exp);
    end
  endtask

  // Drive at the falling edge, let one rising edge pass, sample at the next falling edge.
  task automatic step(input logic [W-1:0] d, input logic [W-1:0] s, input logic st);
    dIn = d; shadowIn = s; stallIn = st;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    @(negedge clk);
    @(negedge clk);
    chk("R1 in reset", {errOut, qOut}, {1'b0, {W{1'b0}}});
    rstN = 1'b1;
    // first edge after reset: agreeing pair, no pending mismatch from reset
    step(4'h5, 4'h5, 1'b0);
    chk("R1 clean start", {errOut, qOut}, {1'b0, 4'h5});

    for (int d = 0; d < N; d++) begin
      for (int s = 0; s < N; s++) begin
        logic [W-1:0] dv;
        logic [W-1:0] sv;
        dv = W'(d);
        sv = W'(s);
        step(dv, sv, 1'b0);
        // R2: the main sample is shown first, no error yet
        chk("R2 capture", {errOut, qOut}, {1'b0, dv});
        if (dv != sv) begin
          if (dv[0]) begin
            // R5: a stall ahead of the correction keeps the bad value, ignores inputs
            step(~dv, ~sv, 1'b1);
            chk("R5 stall pending", {errOut, qOut}, {1'b0, dv});
          end
          // R4: correction edge ignores inputs; R3: any differing bit triggers it
          step(~dv, dv, 1'b0);
          chk($sformatf("R4/R3 restore diff=%b", dv ^ sv), {errOut, qOut}, {1'b1, sv});
          if (s % 3 == 0) begin
            // R5: a global stall after the correction holds and stays quiet (R6)
            step(dv, ~sv, 1'b1);
            chk("R5 stall hold", {errOut, qOut}, {1'b0, sv});
          end
        end
      end
    end

    // R7: every slot failing still advances one word per two edges
    for (int k = 0; k < N; k++) begin
      logic [W-1:0] good;
      good = W'(k * 5 + 3);
      step(~good, good, 1'b0);
      chk("R7 bad capture", {errOut, qOut}, {1'b0, ~good});
      step(good ^ 4'h6, good, 1'b0);
      chk("R7 restore", {errOut, qOut}, {1'b1, good});
    end
    step(4'hA, 4'hA, 1'b0);
    chk("R7/R6 capture after restore", {errOut, qOut}, {1'b0, 4'hA});

    // R1: reset in mid-run clears a pending mismatch
    step(4'h3, 4'hC, 1'b0);
    rstN = 1'b0;
    step(4'hF, 4'h0, 1'b0);
    chk("R1 mid-run reset", {errOut, qOut}, {1'b0, 4'h0});
    rstN = 1'b1;
    step(4'h9, 4'h9, 1'b0);
    chk("R1 no stale mismatch", {errOut, qOut}, {1'b0, 4'h9});
    step(4'h2, 4'h2, 1'b0);
    chk("R1 no stale error", {errOut, qOut}, {1'b0, 4'h2});

    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 200000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog: actual running expected finished");
    end
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule